// File: doc/BRIEF.md
# Data-Processing ALU with Flag Register

This block is the arithmetic and logic stage of a 32-bit load/store processor. Each cycle it takes one data-processing operation: a 4-bit opcode, the first operand, and a second operand that arrives already shifted from the barrel shifter, along with the shifter's carry-out. The second operand can instead come from a 12-bit immediate field, which the block decodes itself. It returns the 32-bit result in the same cycle, together with a write enable for the destination register and a flush request when that destination is the program counter.

The four condition flags (negative, zero, carry, overflow) are held in a register inside the block. That register loads only when the operation asks for a flag update, and the new values appear on the flag outputs one clock after the operation is presented. The carry and overflow values used as inputs, for carry-chained arithmetic and for logical operations that keep overflow, come in as ports from the status register, which sits outside this block.

Top module: `dp_alu`

## Requirements
- R1: The opcode selects the operation as 0 AND, 1 EOR, 2 SUB (a-b), 3 RSB (b-a), 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST, 9 TEQ, 10 CMP, 11 CMN, 12 ORR, 13 MOV (b), 14 BIC (a AND NOT b), 15 MVN (NOT b), and `alu_result` carries that result in the same cycle.
- R2: `result_we` is 0 for opcodes 8 to 11 (test and compare) and 1 for every other opcode.
- R3: After a flag update, `flag_n` equals bit 31 of the result and `flag_z` is 1 exactly when the 32-bit result is zero.
- R4: For ADD, ADC and CMN the carry flag is bit 32 of the 33-bit unsigned sum, and overflow is set when both addends have the same sign and the result sign differs from it.
- R5: ADC adds `carry_in`; SBC computes a-b+carry_in-1 and RSC computes b-a+carry_in-1.
- R6: For SUB, RSB, SBC, RSC and CMP the carry flag is 1 when no borrow occurs, and overflow is set when the signed difference does not fit in 32 bits.
- R7: For the logical opcodes (0, 1, 8, 9, 12, 13, 14, 15) the carry flag takes `shift_carry` and the overflow flag takes `ovf_in` unchanged.
- R8: The flag register loads on a clock edge only when `set_flags` is 1 or the opcode is 8 to 11; otherwise all four flags keep their values.
- R9: When `use_imm` is 1, operand 2 is bits 7:0 of `imm_field` rotated right by twice the value of bits 11:8; otherwise it is `opnd_b`.
- R10: `pc_flush` is 1 exactly when `result_we` is 1 and `dest_idx` is 15.
- R11: A clock edge with `rst_n` low clears all four flags to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 4 | Operation select |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Shifted second operand |
| shift_carry | input | 1 | Shifter carry-out |
| use_imm | input | 1 | Take operand 2 from the immediate field |
| imm_field | input | 12 | Rotate amount (11:8) and 8-bit value (7:0) |
| carry_in | input | 1 | Current carry flag |
| ovf_in | input | 1 | Current overflow flag |
| set_flags | input | 1 | Request a flag update |
| dest_idx | input | 4 | Destination register number |
| alu_result | output | 32 | Operation result |
| result_we | output | 1 | Destination write enable |
| pc_flush | output | 1 | Pipeline flush on write to register 15 |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry flag |
| flag_v | output | 1 | Registered overflow flag |

## Verification
The bench targets the carry convention of subtraction: a design that treats carry as a borrow would report C=0 for 5-3 and C=1 for 3-5, and one that forgets to swap operands for RSB or RSC returns the negated difference. It drives carry-chained operations with both values of `carry_in`, so an SBC that ignores the input is off by one in half the cases, and it drives signed boundary values such as 0x7FFFFFFF+1 and 0x80000000-1 where a wrong overflow rule misses the wrap. It also presents flag-neutral operations after a flag update to catch a register that loads on every cycle, immediates with rotate amounts of zero and ones that wrap bits across the word, and writes to register 15 from both a writing and a compare opcode.

// File: rtl/dp_alu_pkg.sv
// Shared types for the data-processing ALU.
// Assumes: opcode numbering is fixed by the instruction encoding.
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
        OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
        OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    // Test and compare operations: flags only, no register write.
    function automatic logic op_is_test(input alu_op_e op);
        return (op == OP_TST) || (op == OP_TEQ) || (op == OP_CMP) || (op == OP_CMN);
    endfunction

    // Operations whose carry comes from the shifter and whose overflow is kept.
    function automatic logic op_is_logical(input alu_op_e op);
        case (op)
            OP_AND, OP_EOR, OP_TST, OP_TEQ,
            OP_ORR, OP_MOV, OP_BIC, OP_MVN: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dp_alu_imm.sv
// Immediate operand decoder: rotates an IMM_W-bit value right by twice
// the ROT_W-bit rotate field, zero-extended to DATA_W bits.
// Assumes: 2**ROT_W * 2 <= DATA_W so one doubled word covers every rotation.
module dp_alu_imm #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic [ROT_W+IMM_W-1:0] imm_field,
    output logic [DATA_W-1:0]      imm_value
);
    localparam int AMT_W = ROT_W + 1;

    logic [DATA_W-1:0]   base;
    logic [AMT_W-1:0]    amount;
    logic [2*DATA_W-1:0] doubled;

    // Zero-extend the value and compute the even rotate amount.
    always_comb begin
        base    = '0;
        base[IMM_W-1:0] = imm_field[IMM_W-1:0];
        amount  = {imm_field[ROT_W+IMM_W-1:IMM_W], 1'b0};
        doubled = {base, base} >> amount;
        imm_value = doubled[DATA_W-1:0];
    end

endmodule

// File: rtl/dp_alu_core.sv
// Combinational ALU core: one shared adder serves all eight arithmetic
// operations by swapping and inverting operands; logic ops bypass it.
// Produces the result and the candidate flag values.
// Assumes: opnd_b is already shifted and shift_carry is the shifter carry-out.
module dp_alu_core
    import dp_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              shift_carry,
    input  logic              carry_in,
    input  logic              ovf_in,
    output logic [DATA_W-1:0] result,
    output nzcv_t             flags_next
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] add_x, add_y, logic_res;
    logic              add_ci;
    logic [DATA_W:0]   sum;

    // Pick adder inputs per arithmetic op and compute the logical result.
    always_comb begin
        add_x  = a;
        add_y  = b;
        add_ci = 1'b0;
        logic_res = '0;
        case (op)
            OP_SUB, OP_CMP: begin add_y = ~b; add_ci = 1'b1; end
            OP_RSB:         begin add_x = b; add_y = ~a; add_ci = 1'b1; end
            OP_ADC:         add_ci = carry_in;
            OP_SBC:         begin add_y = ~b; add_ci = carry_in; end
            OP_RSC:         begin add_x = b; add_y = ~a; add_ci = carry_in; end
            OP_AND, OP_TST: logic_res = a & b;
            OP_EOR, OP_TEQ: logic_res = a ^ b;
            OP_ORR:         logic_res = a | b;
            OP_MOV:         logic_res = b;
            OP_BIC:         logic_res = a & ~b;
            OP_MVN:         logic_res = ~b;
            default:        ;
        endcase
    end

    // Single 33-bit adder; bit DATA_W is the carry (no-borrow for subtracts).
    always_comb sum = {1'b0, add_x} + {1'b0, add_y} + {{DATA_W{1'b0}}, add_ci};

    // Select the result and derive N, Z, C, V.
    always_comb begin
        result       = op_is_logical(op) ? logic_res : sum[MSB:0];
        flags_next.n = result[MSB];
        flags_next.z = (result == '0);
        if (op_is_logical(op)) begin
            flags_next.c = shift_carry;
            flags_next.v = ovf_in;
        end else begin
            flags_next.c = sum[DATA_W];
            flags_next.v = (add_x[MSB] == add_y[MSB]) && (sum[MSB] != add_x[MSB]);
        end
    end

endmodule

// File: rtl/dp_alu_flags.sv
// Condition-flag register: loads the candidate flags when asked, holds
// them otherwise. Synchronous active-low reset clears all four.
module dp_alu_flags
    import dp_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  nzcv_t             flags_next,
    input  logic [DATA_W-1:0] result,
    output nzcv_t             flags_q
);
    // Flag storage with conditional load.
    always_ff @(posedge clk) begin
        if (!rst_n)    flags_q <= '0;
        else if (load) flags_q <= flags_next;
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(flags_q));

    p_zero_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (flags_q.z == ($past(result) == '0)) && (flags_q.n == $past(result[DATA_W-1])));

endmodule

// File: rtl/dp_alu.sv
// Data-processing ALU top: immediate decode, operand select, ALU core,
// write-enable and flush generation, and the flag register.
// Assumes: register file, shifter and status-register banking are external.
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4,
    parameter int IDX_W  = 4,
    parameter int PC_IDX = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [3:0]              opcode,
    input  logic [DATA_W-1:0]       opnd_a,
    input  logic [DATA_W-1:0]       opnd_b,
    input  logic                    shift_carry,
    input  logic                    use_imm,
    input  logic [ROT_W+IMM_W-1:0]  imm_field,
    input  logic                    carry_in,
    input  logic                    ovf_in,
    input  logic                    set_flags,
    input  logic [IDX_W-1:0]        dest_idx,
    output logic [DATA_W-1:0]       alu_result,
    output logic                    result_we,
    output logic                    pc_flush,
    output logic                    flag_n,
    output logic                    flag_z,
    output logic                    flag_c,
    output logic                    flag_v
);
    localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_IDX);

    alu_op_e           op;
    logic [DATA_W-1:0] imm_value, opnd2;
    nzcv_t             flags_next, flags_q;
    logic              flag_load;

    dp_alu_imm #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) imm_i (
        .imm_field (imm_field),
        .imm_value (imm_value)
    );

    // Decode opcode and choose operand 2.
    always_comb begin
        op    = alu_op_e'(opcode);
        opnd2 = use_imm ? imm_value : opnd_b;
    end

    dp_alu_core #(.DATA_W(DATA_W)) core_i (
        .op          (op),
        .a           (opnd_a),
        .b           (opnd2),
        .shift_carry (shift_carry),
        .carry_in    (carry_in),
        .ovf_in      (ovf_in),
        .result      (alu_result),
        .flags_next  (flags_next)
    );

    // Write enable, flush request and flag-load condition.
    always_comb begin
        result_we = !op_is_test(op);
        pc_flush  = result_we && (dest_idx == PC_SEL);
        flag_load = set_flags || op_is_test(op);
    end

    dp_alu_flags #(.DATA_W(DATA_W)) flags_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (flag_load),
        .flags_next (flags_next),
        .result     (alu_result),
        .flags_q    (flags_q)
    );

    // Drive the flag ports from the register.
    always_comb begin
        flag_n = flags_q.n;
        flag_z = flags_q.z;
        flag_c = flags_q.c;
        flag_v = flags_q.v;
    end

    p_test_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[3:2] == 2'b10) |-> !result_we);

    p_flush_pc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pc_flush |-> (result_we && dest_idx == PC_SEL));

    p_logic_keeps_v_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_load && op_is_logical(op)) |=> (flag_v == $past(ovf_in)) && (flag_c == $past(shift_carry)));

    p_reset_clear_r11: assert property (@(posedge clk)
        !rst_n |=> !(flag_n || flag_z || flag_c || flag_v));

endmodule

// File: tb/dp_alu_tb_top.sv
module dp_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  opcode = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic        shift_carry = 1'b0, use_imm = 1'b0;
    logic [11:0] imm_field = '0;
    logic        carry_in = 1'b0, ovf_in = 1'b0, set_flags = 1'b0;
    logic [3:0]  dest_idx = '0;
    logic [31:0] alu_result;
    logic        result_we, pc_flush, flag_n, flag_z, flag_c, flag_v;

    int total = 0;
    int bad   = 0;
    logic en, ez, ec, ev;   // expected registered flags

    always #10 clk = ~clk;  // 50 MHz

    dp_alu dut_i (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .shift_carry(shift_carry), .use_imm(use_imm), .imm_field(imm_field),
        .carry_in(carry_in), .ovf_in(ovf_in), .set_flags(set_flags), .dest_idx(dest_idx),
        .alu_result(alu_result), .result_we(result_we), .pc_flush(pc_flush),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
    );

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog: run did not finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Independent reference from the requirements using wide signed/unsigned math.
    task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic sc, input logic ci, input logic vi,
                         output logic [31:0] r, output logic c, output logic v, output logic we);
        longint ua, ub, sa, sb, u, s;
        ua = longint'({32'b0, a}); ub = longint'({32'b0, b});
        sa = longint'($signed(a)); sb = longint'($signed(b));
        u = 0; s = 0; c = sc; v = vi; r = '0;
        case (op)
            4'd0, 4'd8:  r = a & b;
            4'd1, 4'd9:  r = a ^ b;
            4'd12:       r = a | b;
            4'd13:       r = b;
            4'd14:       r = a & ~b;
            4'd15:       r = ~b;
            4'd2, 4'd10: begin u = ua - ub; s = sa - sb; end
            4'd3:        begin u = ub - ua; s = sb - sa; end
            4'd4, 4'd11: begin u = ua + ub; s = sa + sb; end
            4'd5:        begin u = ua + ub + ci; s = sa + sb + ci; end
            4'd6:        begin u = ua - ub + ci - 1; s = sa - sb + ci - 1; end
            default:     begin u = ub - ua + ci - 1; s = sb - sa + ci - 1; end
        endcase
        if (op inside {[4'd2:4'd7], 4'd10, 4'd11}) begin
            r = u[31:0];
            if (op inside {4'd4, 4'd5, 4'd11}) c = (u > 64'sh0_FFFF_FFFF);
            else                               c = (u >= 0);
            v = (s > 64'sh7FFF_FFFF) || (s < -64'sh8000_0000);
        end
        we = !(op inside {[4'd8:4'd11]});
    endtask

    // Apply one operation at the falling edge, check outputs, then flags after the edge.
    task automatic run_op(input string tag, input logic [3:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic sc, input logic ci,
                          input logic vi, input logic sf, input logic [3:0] dst);
        logic [31:0] r; logic c, v, we, upd;
        @(negedge clk);
        opcode = op; opnd_a = a; opnd_b = b; shift_carry = sc; carry_in = ci;
        ovf_in = vi; set_flags = sf; dest_idx = dst; use_imm = 1'b0;
        model(op, a, b, sc, ci, vi, r, c, v, we);
        upd = sf || (op inside {[4'd8:4'd11]});
        #2;
        chk({tag, " R1 result"}, alu_result, r);
        chk({tag, " R2 write enable"}, 32'(result_we), 32'(we));
        @(posedge clk); #2;
        if (upd) begin en = r[31]; ez = (r == 0); ec = c; ev = v; end
        chk({tag, " R3 N/Z R8"}, {30'b0, flag_n, flag_z}, {30'b0, en, ez});
        chk({tag, " C/V R4 R6 R7"}, {30'b0, flag_c, flag_v}, {30'b0, ec, ev});
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        en = 0; ez = 0; ec = 0; ev = 0;
        chk("R11 flags after reset", {28'b0, flag_n, flag_z, flag_c, flag_v}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_logic;
        run_op("R7 AND", 4'd0,  32'hF0F0_1234, 32'h0FF0_FFFF, 1'b1, 1'b0, 1'b1, 1'b1, 4'd1);
        run_op("R7 EOR", 4'd1,  32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0, 1'b1, 1'b0, 1'b1, 4'd2);
        run_op("R7 ORR", 4'd12, 32'h8000_0000, 32'h0000_0001, 1'b0, 1'b0, 1'b1, 1'b1, 4'd3);
        run_op("R7 MOV", 4'd13, 32'h1234_5678, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b1, 4'd4);
        run_op("R7 BIC", 4'd14, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b0, 1'b0, 1'b0, 1'b1, 4'd5);
        run_op("R7 MVN", 4'd15, 32'h0,         32'h0000_0000, 1'b1, 1'b0, 1'b1, 1'b1, 4'd6);
    endtask

    task automatic t_arith;
        run_op("R4 ADD wrap",    4'd4, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1);
        run_op("R4 ADD ovf",     4'd4, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1);
        run_op("R6 SUB noborrow",4'd2, 32'd5, 32'd3, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1);
        run_op("R6 SUB borrow",  4'd2, 32'd3, 32'd5, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1);
        run_op("R6 SUB ovf",     4'd2, 32'h8000_0000, 32'd1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1);
        run_op("R6 RSB",         4'd3, 32'd3, 32'd10, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1);
        run_op("R6 RSB ovf",     4'd3, 32'd1, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1);
    endtask

    task automatic t_carry_chain;
        for (int ci = 0; ci < 2; ci++) begin
            run_op("R5 ADC", 4'd5, 32'hFFFF_FFFE, 32'd1, 1'b0, 1'(ci), 1'b0, 1'b1, 4'd2);
            run_op("R5 SBC", 4'd6, 32'd7, 32'd7, 1'b0, 1'(ci), 1'b0, 1'b1, 4'd2);
            run_op("R5 RSC", 4'd7, 32'd2, 32'd9, 1'b0, 1'(ci), 1'b0, 1'b1, 4'd2);
            run_op("R5 SBC ovf", 4'd6, 32'h8000_0000, 32'd0, 1'b0, 1'(ci), 1'b0, 1'b1, 4'd2);
        end
    endtask

    task automatic t_compare;
        run_op("R2 TST", 4'd8,  32'hFF00_0000, 32'h00FF_0000, 1'b1, 1'b0, 1'b1, 1'b0, 4'd7);
        run_op("R2 TEQ", 4'd9,  32'h8000_0000, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7);
        run_op("R2 CMP", 4'd10, 32'd4, 32'd4, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7);
        run_op("R2 CMN", 4'd11, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7);
    endtask

    // R8: set_flags low on non-test ops must leave flags unchanged.
    task automatic t_hold;
        run_op("R8 setup CMP", 4'd10, 32'd1, 32'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
        run_op("R8 hold ADD",  4'd4,  32'd0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
        run_op("R8 hold MOV",  4'd13, 32'd0, 32'd5, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0);
    endtask

    task automatic t_imm;
        logic [11:0] fields [4] = '{12'h0AB, 12'h1FF, 12'h4C3, 12'hF81};
        for (int i = 0; i < 4; i++) begin
            logic [31:0] ext, exp;
            int amt;
            @(negedge clk);
            opcode = 4'd13; use_imm = 1'b1; imm_field = fields[i];
            opnd_b = 32'hDEAD_BEEF; set_flags = 1'b0; dest_idx = 4'd1;
            ext = {24'b0, fields[i][7:0]};
            amt = 2 * int'(fields[i][11:8]);
            exp = ext;
            for (int k = 0; k < amt; k++) exp = {exp[0], exp[31:1]};
            #2;
            chk("R9 immediate rotate", alu_result, exp);
        end
        @(negedge clk); use_imm = 1'b0;
    endtask

    task automatic t_flush;
        @(negedge clk);
        use_imm = 1'b0; set_flags = 1'b0; opcode = 4'd13; dest_idx = 4'd15; #2;
        chk("R10 MOV to 15 flush", 32'(pc_flush), 32'd1);
        @(negedge clk); dest_idx = 4'd14; #2;
        chk("R10 MOV to 14 no flush", 32'(pc_flush), 32'd0);
        @(negedge clk); opcode = 4'd10; dest_idx = 4'd15; #2;
        chk("R10 CMP to 15 no flush", 32'(pc_flush), 32'd0);
        @(negedge clk); opcode = 4'd4; #2;
        chk("R10 ADD to 15 flush", 32'(pc_flush), 32'd1);
    endtask

    initial begin
        en = 0; ez = 0; ec = 0; ev = 0;
        t_reset();
        t_logic();
        t_arith();
        t_carry_chain();
        t_compare();
        t_hold();
        t_imm();
        t_flush();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule